// File: doc/BRIEF.md
# ADC Result Read-Out Port

This block is the digital read-out side of a 16-bit successive-approximation converter. Each finished conversion arrives as a data word with a one-cycle latch strobe. The block holds the word and presents it on a 16-pin output group in one of two ways. In parallel mode it drives all 16 bits. In serial mode four of the low pins change role and become serial data out, serial clock, frame sync and a read-overrun error flag. The top four pins always carry the top four result bits, in either mode. The result can be given as straight offset binary or as two's complement.

The serial port has two clock modes. In internal (master) mode the block divides its system clock and sends a framed burst of 16 bits, with sync asserted for the whole burst. In external (slave) mode the host supplies the serial clock, which is sampled in the system clock domain and gated by chip-select. The edge that advances the data is selectable. A read that is still unfinished when the next result lands loses its data, and the error flag gives a one-cycle pulse. Every pin has its own output enable so that a tri-state pad can be modelled. Pins in the low group are enabled only while chip-select and read are both low (active-low).

Top module: `adc_rdout_port`

## Requirements
- R1: With `ser_sel`=0 and the bus enabled, `pin_d[15:0]` carries the formatted held result one clock after `res_stb` is sampled, and `pin_oe[11:0]` is all ones.
- R2: `pin_oe[15:12]` is always 1, and `pin_d[15:12]` always carries the top four formatted result bits, whatever the values of `ser_sel`, `cs_n` and `rd_n`.
- R3: Format: with `fmt_twos`=0 the word is passed through unchanged (offset binary). With `fmt_twos`=1 bit 15 is inverted (two's complement). The serial shift register takes the format in force when it is loaded.
- R4: The low pin group is enabled only while `cs_n`=0 and `rd_n`=0. Otherwise `pin_oe[11:0]` is all zeros.
- R5: Serial pin map: `pin_d[8]` = data out, `pin_d[9]` = serial clock, `pin_d[10]` = frame sync, `pin_d[11]` = read error. Data leaves MSB first. A load presents bit 15 at once, and each active clock edge advances by one bit. After 16 advances the data pin shows 0.
- R6: In external mode (`clk_ext`=1) the active edge of `sclk_in` is the rising edge when `sclk_inv`=0 and the falling edge when `sclk_inv`=1. The data pin changes one system clock after the edge is sampled.
- R7: In external mode, edges of `sclk_in` that occur while `cs_n`=1 are ignored and do not advance the data.
- R8: In internal mode a read starts on the clock after the bus enable rises, provided the block is idle. It produces 16 clock pulses on `pin_d[9]`. Each bit lasts 4*QTR system clocks: the clock is low for the first quarter and the last quarter, and high for the middle half. The data changes only at bit boundaries, and `pin_oe[9]` is 1 only during the burst.
- R9: In internal mode the sync pin is active for exactly 64*QTR clocks from the start of a read. It is active high when `sync_inv`=0 and active low when `sync_inv`=1. `pin_oe[10]` is 1 whenever the bus is enabled in internal serial mode.
- R10: In external serial mode, if `res_stb` arrives after 1 to 15 active edges of the current word, `pin_d[11]` pulses high for one clock. In the same cycle the new word replaces the unread one. No pulse occurs after 0 or 16 edges.
- R11: In serial mode `pin_oe[7:0]` is 0. In external mode `pin_oe[9]` and `pin_oe[10]` are 0 and `pin_oe[11]` follows the bus enable. In internal mode `pin_oe[11]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_data | input | 16 | Conversion result, offset binary |
| res_stb | input | 1 | One-cycle strobe: latch `res_data` |
| ser_sel | input | 1 | 1 = serial port, 0 = parallel bus |
| fmt_twos | input | 1 | 1 = two's complement output |
| clk_ext | input | 1 | 1 = external serial clock (slave) |
| sclk_inv | input | 1 | External mode: 1 = falling edge advances data |
| sync_inv | input | 1 | Internal mode: 1 = sync active low |
| cs_n | input | 1 | Chip-select, active low |
| rd_n | input | 1 | Read, active low |
| sclk_in | input | 1 | External serial clock |
| pin_d | output | 16 | Pin data values |
| pin_oe | output | 16 | Per-pin output enables |

## Verification
The bench goes after the edge choice in slave mode. A design that took the wrong edge would advance the data half a clock early, and the data pin would disagree with the model on the cycle after the first edge. It toggles the serial clock with chip-select high. A design that did not gate the clock would lose leading bits. It sends an overrun strobe part-way through a read and another strobe after a full read, so a design that tested the wrong edge count would pulse on the wrong one or on both. In master mode it counts the clock pulses and the sync width for both sync polarities, which exposes an off-by-one in the bit counter or an inverted sync.

// File: rtl/adc_rdout_pkg.sv
package adc_rdout_pkg;

  // Offset binary to two's complement only flips the sign bit.
  function automatic logic fmt_top_bit(input logic msb, input logic twos);
    return msb ^ twos;
  endfunction

  // Internal serial clock is high in the middle half of a bit period.
  function automatic logic sclk_level(input int unsigned phase, input int unsigned qtr);
    return (phase >= qtr) && (phase < 3 * qtr);
  endfunction

  // Slave-mode overrun: a read has begun and is not yet complete.
  function automatic logic read_open(input int unsigned done_bits, input int unsigned nbits);
    return (done_bits != 0) && (done_bits < nbits);
  endfunction

endpackage

// File: rtl/adc_rdout_clkgen.sv
module adc_rdout_clkgen #(
  parameter int unsigned QTR   = 1,
  parameter int unsigned NBITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic sclk,
  output logic shift
);
  import adc_rdout_pkg::*;

  localparam int unsigned PER = 4 * QTR;
  localparam int unsigned PW  = (PER > 1) ? $clog2(PER) : 1;
  localparam int unsigned BW  = (NBITS > 1) ? $clog2(NBITS) : 1;

  logic [PW-1:0] phase;
  logic [BW-1:0] bit_idx;
  logic          last_ph;
  logic          last_bit;

  assign last_ph  = (phase == PW'(PER - 1));
  assign last_bit = (bit_idx == BW'(NBITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      phase   <= '0;
      bit_idx <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      phase   <= '0;
      bit_idx <= '0;
    end else if (busy) begin
      if (last_ph) begin
        phase <= '0;
        if (last_bit) busy <= 1'b0;
        else          bit_idx <= bit_idx + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign shift = busy && last_ph && !last_bit;
  assign sclk  = busy && sclk_level(int'(phase), QTR);

endmodule

// File: rtl/adc_rdout_edge.sv
module adc_rdout_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic gate_ok,
  input  logic inv,
  output logic act
);
  logic sclk_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_in;
  end

  assign rise = sclk_in & ~sclk_q;
  assign fall = ~sclk_in & sclk_q;
  assign act  = gate_ok & (inv ? fall : rise);

endmodule

// File: rtl/adc_rdout_shift.sv
module adc_rdout_shift #(
  parameter int unsigned W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_new,
  input  logic [W-1:0]                 new_word,
  input  logic                         load_start,
  input  logic [W-1:0]                 start_word,
  input  logic                         shift,
  input  logic                         overrun_chk,
  output logic                         sdo,
  output logic [$clog2(W+1)-1:0]       cnt,
  output logic                         err
);
  import adc_rdout_pkg::*;

  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
      err <= 1'b0;
    end else begin
      err <= overrun_chk && read_open(int'(cnt), W);
      if (load_new) begin
        sh  <= new_word;
        cnt <= '0;
      end else if (load_start) begin
        sh  <= start_word;
        cnt <= '0;
      end else if (shift) begin
        sh <= {sh[W-2:0], 1'b0};
        if (cnt != CW'(W)) cnt <= cnt + 1'b1;
      end
    end
  end

  assign sdo = sh[W-1];

endmodule

// File: rtl/adc_rdout_pins.sv
module adc_rdout_pins #(
  parameter int unsigned W    = 16,
  parameter int unsigned HI_N = 4
) (
  input  logic         ser,
  input  logic         ext,
  input  logic         en,
  input  logic         sync_inv,
  input  logic         busy,
  input  logic         sclk,
  input  logic         sdo,
  input  logic         err,
  input  logic [W-1:0] word,
  output logic [W-1:0] pin_d,
  output logic [W-1:0] pin_oe
);
  localparam int unsigned LO_N  = W - HI_N;
  localparam int unsigned P_SDO = LO_N - 4;
  localparam int unsigned P_SCK = LO_N - 3;
  localparam int unsigned P_SYN = LO_N - 2;
  localparam int unsigned P_ERR = LO_N - 1;

  always_comb begin
    pin_d  = word;
    pin_oe = {{HI_N{1'b1}}, {LO_N{en}}};
    if (ser) begin
      pin_d[LO_N-1:0]  = '0;
      pin_oe[LO_N-1:0] = '0;
      pin_d[P_SDO]  = sdo;
      pin_oe[P_SDO] = en;
      pin_d[P_SCK]  = sclk & ~ext;
      pin_oe[P_SCK] = en & ~ext & busy;
      pin_d[P_SYN]  = ~ext & (busy ^ sync_inv);
      pin_oe[P_SYN] = en & ~ext;
      pin_d[P_ERR]  = err;
      pin_oe[P_ERR] = en & ext;
    end
  end

endmodule

// File: rtl/adc_rdout_port.sv
module adc_rdout_port #(
  parameter int unsigned W    = 16,
  parameter int unsigned HI_N = 4,
  parameter int unsigned QTR  = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] res_data,
  input  logic         res_stb,
  input  logic         ser_sel,
  input  logic         fmt_twos,
  input  logic         clk_ext,
  input  logic         sclk_inv,
  input  logic         sync_inv,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         sclk_in,
  output logic [W-1:0] pin_d,
  output logic [W-1:0] pin_oe
);
  import adc_rdout_pkg::*;

  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  raw_q;
  logic          en_q;
  logic          en;
  logic          start;
  logic          busy;
  logic          int_sclk;
  logic          int_shift;
  logic          ext_act;
  logic          shift_ev;
  logic          load_ev;
  logic          sh_msb;
  logic [CW-1:0] rd_cnt;
  logic          err_q;
  logic [W-1:0]  fmt_new;
  logic [W-1:0]  fmt_held;

  assign en       = ~cs_n & ~rd_n;
  assign start    = ser_sel & ~clk_ext & en & ~en_q & ~busy;
  assign load_ev  = res_stb & ~busy;
  assign shift_ev = int_shift | ext_act;
  assign fmt_new  = {fmt_top_bit(res_data[W-1], fmt_twos), res_data[W-2:0]};
  assign fmt_held = {fmt_top_bit(raw_q[W-1], fmt_twos), raw_q[W-2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= en;
      if (res_stb) raw_q <= res_data;
    end
  end

  adc_rdout_clkgen #(.QTR(QTR), .NBITS(W)) u_clkgen (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .sclk  (int_sclk),
    .shift (int_shift)
  );

  adc_rdout_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_in (sclk_in),
    .gate_ok (ser_sel & clk_ext & ~cs_n),
    .inv     (sclk_inv),
    .act     (ext_act)
  );

  adc_rdout_shift #(.W(W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_new    (load_ev),
    .new_word    (fmt_new),
    .load_start  (start),
    .start_word  (fmt_held),
    .shift       (shift_ev),
    .overrun_chk (ser_sel & clk_ext & res_stb),
    .sdo         (sh_msb),
    .cnt         (rd_cnt),
    .err         (err_q)
  );

  adc_rdout_pins #(.W(W), .HI_N(HI_N)) u_pins (
    .ser      (ser_sel),
    .ext      (clk_ext),
    .en       (en),
    .sync_inv (sync_inv),
    .busy     (busy),
    .sclk     (int_sclk),
    .sdo      (sh_msb),
    .err      (err_q),
    .word     (fmt_held),
    .pin_d    (pin_d),
    .pin_oe   (pin_oe)
  );

endmodule

// File: rtl/adc_rdout_port_chk.sv
module adc_rdout_port_chk #(
  parameter int unsigned W    = 16,
  parameter int unsigned HI_N = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ser_sel,
  input logic                   clk_ext,
  input logic [W-1:0]           res_data,
  input logic                   fmt_twos,
  input logic                   en,
  input logic                   start,
  input logic                   busy,
  input logic                   int_sclk,
  input logic                   shift_ev,
  input logic                   load_ev,
  input logic                   sh_msb,
  input logic [$clog2(W+1)-1:0] rd_cnt,
  input logic                   err_q,
  input logic [W-1:0]           pin_oe
);
  localparam int unsigned LO_N = W - HI_N;

  assert_hi_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[W-1:LO_N] == '1);

  assert_bus_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> pin_oe[LO_N-1:0] == '0);

  assert_load_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> sh_msb == ($past(res_data[W-1]) ^ $past(fmt_twos)));

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ev && !load_ev && !start && rd_cnt < W) |=> rd_cnt == $past(rd_cnt) + 1'b1);

  assert_sclk_in_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_sclk |-> busy);

  assert_start_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ser_sel && !clk_ext && en));

  assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);

  assert_ser_low_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ser_sel |-> pin_oe[LO_N-5:0] == '0);

endmodule

bind adc_rdout_port adc_rdout_port_chk #(.W(W), .HI_N(HI_N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_sel  (ser_sel),
  .clk_ext  (clk_ext),
  .res_data (res_data),
  .fmt_twos (fmt_twos),
  .en       (en),
  .start    (start),
  .busy     (busy),
  .int_sclk (int_sclk),
  .shift_ev (shift_ev),
  .load_ev  (load_ev),
  .sh_msb   (sh_msb),
  .rd_cnt   (rd_cnt),
  .err_q    (err_q),
  .pin_oe   (pin_oe)
);

// File: tb/adc_rdout_port_tb.sv
module adc_rdout_port_tb_top;
  localparam int CLK_P = 10;
  localparam int W     = 16;
  localparam int QTR   = 1;
  localparam int PER   = 4 * QTR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] res_data = '0;
  logic res_stb = 1'b0, ser_sel = 1'b0, fmt_twos = 1'b0, clk_ext = 1'b0;
  logic sclk_inv = 1'b0, sync_inv = 1'b0, cs_n = 1'b1, rd_n = 1'b1, sclk_in = 1'b0;
  logic [W-1:0] pin_d, pin_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_rdout_port #(.W(W), .HI_N(4), .QTR(QTR)) dut_i (
    .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_stb(res_stb),
    .ser_sel(ser_sel), .fmt_twos(fmt_twos), .clk_ext(clk_ext),
    .sclk_inv(sclk_inv), .sync_inv(sync_inv), .cs_n(cs_n), .rd_n(rd_n),
    .sclk_in(sclk_in), .pin_d(pin_d), .pin_oe(pin_oe));

  // ---------------- reference model ----------------
  int m_raw = 0, m_word = 0, m_sh = 16, m_tick = -1;
  bit m_err = 0, m_sp = 0, m_enp = 0;

  function automatic int fmtf(input int v, input bit twos);
    return twos ? (v ^ 32'h8000) : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_raw = 0; m_word = 0; m_sh = 0; m_tick = -1; m_err = 0; m_sp = 0; m_enp = 0;
    end else begin
      bit en_b, busy_pre, act, start;
      int old_raw;
      en_b     = !cs_n && !rd_n;
      busy_pre = (m_tick >= 0);
      act      = ser_sel && clk_ext && !cs_n &&
                 (sclk_inv ? (m_sp && !sclk_in) : (!m_sp && sclk_in));
      start    = ser_sel && !clk_ext && en_b && !m_enp && !busy_pre;
      m_err    = ser_sel && clk_ext && res_stb && (m_sh >= 1) && (m_sh <= 15);
      old_raw  = m_raw;
      if (busy_pre) begin
        if (m_tick == 16*PER - 1) m_tick = -1;
        else begin
          if (m_tick % PER == PER - 1) m_sh++;
          m_tick++;
        end
      end
      if (start) m_tick = 0;
      if (res_stb) m_raw = int'(res_data);
      if (res_stb && !busy_pre) begin m_word = fmtf(int'(res_data), fmt_twos); m_sh = 0; end
      else if (start) begin m_word = fmtf(old_raw, fmt_twos); m_sh = 0; end
      else if (act && m_sh < 16) m_sh++;
      m_sp  = sclk_in;
      m_enp = en_b;
    end
  end

  task automatic chk(input string req, input int act_v, input int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act_v, exp_v, $time);
    end
  endtask

  // per-cycle comparison against the model
  int sck_pulses = 0, err_pulses = 0;
  bit last9 = 0, last11 = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit en_b, busy_m, sck_m;
      int fw;
      logic [W-1:0] eoe;
      en_b   = !cs_n && !rd_n;
      busy_m = (m_tick >= 0);
      sck_m  = busy_m && ((m_tick % PER) >= QTR) && ((m_tick % PER) < 3*QTR);
      fw     = fmtf(m_raw, fmt_twos);
      chk("R2 hi pins", {pin_oe[15:12], pin_d[15:12]}, {4'hF, fw[15:12]});
      if (!ser_sel) begin
        eoe = {4'hF, {12{en_b}}};
        chk("R4 parallel oe", int'(pin_oe), int'(eoe));
        if (en_b) chk("R1/R3 parallel data", int'(pin_d[11:0]), fw & 32'hFFF);
      end else begin
        eoe = '0;
        eoe[15:12] = 4'hF;
        eoe[8]  = en_b;
        eoe[9]  = en_b && !clk_ext && busy_m;
        eoe[10] = en_b && !clk_ext;
        eoe[11] = en_b && clk_ext;
        chk("R11 serial oe", int'(pin_oe), int'(eoe));
        if (en_b) chk("R5/R6/R7 serial data", int'(pin_d[8]),
                      (m_sh < 16) ? ((m_word >> (15 - m_sh)) & 1) : 0);
        if (eoe[9])  chk("R8 serial clock", int'(pin_d[9]), int'(sck_m));
        if (eoe[10]) chk("R9 sync", int'(pin_d[10]), int'(busy_m ^ sync_inv));
        if (eoe[11]) chk("R10 error", int'(pin_d[11]), int'(m_err));
      end
      if (pin_oe[9] && pin_d[9] && !last9) sck_pulses++;
      if (pin_oe[11] && pin_d[11] && !last11) err_pulses++;
      last9  = pin_oe[9] && pin_d[9];
      last11 = pin_oe[11] && pin_d[11];
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe(input logic [W-1:0] v);
    res_data = v; res_stb = 1'b1; step(1); res_stb = 1'b0;
  endtask

  task automatic sedges(input int n);
    for (int i = 0; i < n; i++) begin
      sclk_in = ~sclk_in; step(3);
      sclk_in = ~sclk_in; step(3);
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1; step(1);
    @(negedge clk);
    chk("R2 reset hi oe", int'(pin_oe[15:12]), 4'hF);
    chk("R4 reset low oe", int'(pin_oe[11:0]), 0);
    step(1);

    // parallel mode, both formats
    cs_n = 0; rd_n = 0;
    strobe(16'h1234); step(2);
    @(negedge clk); chk("R1 parallel word", int'(pin_d), 32'h1234);
    step(1);
    fmt_twos = 1; step(1);
    @(negedge clk); chk("R3 twos word", int'(pin_d), 32'h9234);
    step(1);
    strobe(16'h8000); step(2);
    @(negedge clk); chk("R3 midscale twos", int'(pin_d), 0);
    step(1);
    rd_n = 1; step(2);
    @(negedge clk); chk("R4 read high disables", int'(pin_oe[11:0]), 0);
    step(1);
    fmt_twos = 0;

    // external clock, rising edge
    ser_sel = 1; clk_ext = 1; sclk_inv = 0; rd_n = 0; cs_n = 0;
    strobe(16'hA5C3); step(2);
    sedges(16); step(2);
    strobe(16'h0F0F); step(2);                 // full read: no pulse
    chk("R10 no pulse after full read", err_pulses, 0);

    // external, falling edge, gated by chip-select
    sclk_inv = 1; fmt_twos = 1;
    strobe(16'h3C96); step(2);
    cs_n = 1; sedges(4); cs_n = 0; step(2);
    @(negedge clk); chk("R7 gated edges ignored", int'(pin_d[8]), 1);
    step(1);
    sedges(16); step(2);
    fmt_twos = 0;

    // overrun mid-read
    sclk_inv = 0;
    strobe(16'hFFFF); step(2);
    sedges(5);
    strobe(16'h1357); step(3);
    chk("R10 overrun pulse", err_pulses, 1);
    sedges(16); step(2);

    // internal clock, both sync polarities
    cs_n = 1; rd_n = 1; clk_ext = 0; sync_inv = 0;
    strobe(16'hC35A); step(2);
    sck_pulses = 0;
    cs_n = 0; rd_n = 0; step(16*PER + 8);
    chk("R8 sixteen clock pulses", sck_pulses, 16);
    rd_n = 1; step(2);
    sync_inv = 1; fmt_twos = 1;
    strobe(16'h0001); step(2);
    sck_pulses = 0;
    rd_n = 0; step(10);
    strobe(16'h7777);                          // during burst: held only
    step(16*PER);
    chk("R9 burst with inverted sync", sck_pulses, 16);
    rd_n = 1; step(4);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule